// File: doc/BRIEF.md
# Multi-Target Parallel Configuration Loader

This controller sits on the host side of a shared byte-wide configuration bus. Several target devices share one clock, one 8-bit data bus, one active-low write strobe and one busy line. Each target has its own active-low chip select. Image bytes arrive on a ready/valid stream. Every byte carries a target index and a last-byte marker.

The loader opens a transfer on the target named by the first byte of an image. It places each byte on the bus and holds it there for as long as busy stays high. After the byte marked last has been taken, it closes the transfer. Once every target has received at least one image, it stops accepting stream data and waits for the shared done line. A programmable timeout flags a done line that never rises. Status outputs show whether a transfer is open, which target it serves, and how many bytes that target has taken so far.

Top module: `multi_cfg_loader`

## Requirements
- R1: After reset, every chip select and the write strobe are high, the bus output enable is low, the stream ready is high, and the loading flag, startup flag, timeout flag and byte count are all zero.
- R2: The index carried by the first byte of an image selects the target. From the cycle after that byte's handshake, only that target's chip select is low, the write strobe is low, the byte is on the bus, and the active-target output equals the index. Indices on later bytes of the same image are ignored.
- R3: If busy is high at a rising edge while a byte is on the bus, that byte stays on the bus at the next edge. The chip select and write strobe stay low, and the stream ready is low.
- R4: A byte on the bus counts as taken at a rising edge where busy is low. If the next byte was handshaken at that same edge, it is on the bus in the following cycle.
- R5: Whenever no byte is waiting inside an open transfer, the chip select and the write strobe are released together. They are also asserted together again, so the write strobe never changes level while a chip select stays low.
- R6: While the last byte of an image is on the bus, the stream ready is low. In the cycle after that byte is taken, every chip select and the write strobe are high.
- R7: The bus output enable is high only while the write strobe is low.
- R8: The byte count clears to zero when a target's transfer opens. It then rises by one for every byte taken, and keeps its value after the transfer closes.
- R9: The done line is ignored until every target has completed at least one image. After that, the stream ready stays low, and the startup flag rises in the cycle after done is seen high, then stays high.
- R10: Once every target is loaded, the timeout flag rises exactly N cycles later if done has not been seen, where N is the timeout limit input. The flag stays high. A limit of zero disables the timeout.
- R11: At most one chip select is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with all targets |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte ready |
| s_data | input | 8 | Stream image byte |
| s_tgt | input | IDX_W | Target index, used on the first byte of an image |
| s_last | input | 1 | Marks the final byte of an image |
| cs_n | output | N_TGT | Active-low chip select, one bit per target |
| wr_n | output | 1 | Shared active-low write strobe |
| bus_d | output | 8 | Shared configuration data bus |
| bus_oe | output | 1 | Output enable for the data bus driver |
| busy | input | 1 | Shared busy line from the targets |
| cfg_done | input | 1 | Shared done line from the targets |
| to_limit | input | TO_W | Done-wait timeout in cycles, 0 disables it |
| loading | output | 1 | A target transfer is open |
| active_tgt | output | IDX_W | Index of the target being loaded |
| byte_cnt | output | CNT_W | Bytes taken by the current or most recent target |
| startup_go | output | 1 | Done seen after every target was loaded |
| done_timeout | output | 1 | Done did not rise within the limit |

## Verification
A stream handshake at one edge puts the byte on the bus from the next cycle. The target takes the byte at the first edge where busy is low. The chip select and write strobe are released one cycle after the last byte is taken. The startup flag follows done by one cycle, and the timeout flag rises exactly the limit number of cycles after the last target finishes. Inputs are driven on the falling edge, and every check samples one nanosecond later. Each check therefore reads the state produced by the rising edges already counted in the scenario. A model target inside the bench records each byte it takes at a rising edge, so the data order and count are checked separately from the loader's own counter.

// File: rtl/multi_cfg_loader.sv
module multi_cfg_loader #(
  parameter int N_TGT = 4,
  parameter int CNT_W = 16,
  parameter int TO_W  = 16,
  localparam int IDX_W = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [7:0]       s_data,
  input  logic [IDX_W-1:0] s_tgt,
  input  logic             s_last,
  output logic [N_TGT-1:0] cs_n,
  output logic             wr_n,
  output logic [7:0]       bus_d,
  output logic             bus_oe,
  input  logic             busy,
  input  logic             cfg_done,
  input  logic [TO_W-1:0]  to_limit,
  output logic             loading,
  output logic [IDX_W-1:0] active_tgt,
  output logic [CNT_W-1:0] byte_cnt,
  output logic             startup_go,
  output logic             done_timeout
);

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_WAIT, ST_UP} st_t;

  st_t              st;
  logic [IDX_W-1:0] cur;
  logic             hold_vld, hold_last;
  logic [7:0]       hold_d;
  logic [CNT_W-1:0] cnt;
  logic [N_TGT-1:0] loaded, loaded_nx;
  logic [TO_W-1:0]  wcnt;
  logic             to_err;
  logic             take, acc, drive;

  assign drive     = (st == ST_XFER) && hold_vld;
  assign acc       = drive && !busy;
  assign s_ready   = (st == ST_IDLE) ||
                     ((st == ST_XFER) && (!hold_vld || (!busy && !hold_last)));
  assign take      = s_valid && s_ready;
  assign loaded_nx = loaded | (N_TGT'(1) << cur);

  assign cs_n         = drive ? ~(N_TGT'(1) << cur) : '1;
  assign wr_n         = !drive;
  assign bus_oe       = drive;
  assign bus_d        = hold_d;
  assign loading      = (st == ST_XFER);
  assign active_tgt   = cur;
  assign byte_cnt     = cnt;
  assign startup_go   = (st == ST_UP);
  assign done_timeout = to_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cur       <= '0;
      hold_vld  <= 1'b0;
      hold_last <= 1'b0;
      hold_d    <= '0;
      cnt       <= '0;
      loaded    <= '0;
      wcnt      <= '0;
      to_err    <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (take) begin
          cur       <= s_tgt;
          hold_vld  <= 1'b1;
          hold_d    <= s_data;
          hold_last <= s_last;
          cnt       <= '0;
          st        <= ST_XFER;
        end
        ST_XFER: begin
          if (acc) begin
            cnt <= cnt + 1'b1;
            if (hold_last) begin
              hold_vld  <= 1'b0;
              hold_last <= 1'b0;
              loaded    <= loaded_nx;
              wcnt      <= '0;
              st        <= (&loaded_nx) ? ST_WAIT : ST_IDLE;
            end else if (take) begin
              hold_d    <= s_data;
              hold_last <= s_last;
            end else begin
              hold_vld <= 1'b0;
            end
          end else if (!hold_vld && take) begin
            hold_vld  <= 1'b1;
            hold_d    <= s_data;
            hold_last <= s_last;
          end
        end
        ST_WAIT: begin
          if (cfg_done) begin
            st <= ST_UP;
          end else if (wcnt != '1) begin
            wcnt <= wcnt + 1'b1;
            if (TO_W'(wcnt + 1'b1) == to_limit) to_err <= 1'b1;
          end
        end
        ST_UP: st <= ST_UP;
        default: st <= ST_IDLE;
      endcase
    end
  end

  logic cs_act;
  assign cs_act = ~&cs_n;

  a_r11_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  a_r5_strobe_steady_under_select: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && $past(cs_act)) |-> $stable(wr_n));

  a_r3_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && busy) |=> (cs_act && $stable(bus_d) && $stable(cs_n)));

  a_r6_no_take_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (drive && hold_last) |-> !s_ready);

  a_r8_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(byte_cnt) |-> (byte_cnt == $past(byte_cnt) + 1'b1 || byte_cnt == '0));

  a_r9_startup_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    startup_go |=> (startup_go && !s_ready));

  a_r10_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done_timeout |=> done_timeout);

endmodule

// File: tb/multi_cfg_loader_bench.sv
`timescale 1ns/1ps
module multi_cfg_loader_bench;
  localparam int NT = 4;

  logic clk = 0, rst_n = 0;
  logic s_valid = 0, s_last = 0, busy = 0, cfg_done = 0;
  logic [7:0] s_data = 0;
  logic [1:0] s_tgt = 0;
  logic [15:0] to_limit = 16'd5;
  logic s_ready, wr_n, bus_oe, loading, startup_go, done_timeout;
  logic [NT-1:0] cs_n;
  logic [7:0] bus_d;
  logic [1:0] active_tgt;
  logic [15:0] byte_cnt;

  int n_chk = 0, n_err = 0;
  logic [7:0] cap [NT][16];
  int cap_n [NT];
  int multi_cs = 0, split_strobe = 0;

  always #2.5 clk = ~clk;

  multi_cfg_loader u_multi_cfg_loader (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_tgt(s_tgt), .s_last(s_last), .cs_n(cs_n),
    .wr_n(wr_n), .bus_d(bus_d), .bus_oe(bus_oe), .busy(busy),
    .cfg_done(cfg_done), .to_limit(to_limit), .loading(loading),
    .active_tgt(active_tgt), .byte_cnt(byte_cnt),
    .startup_go(startup_go), .done_timeout(done_timeout));

  // model targets: take a byte at a rising edge when selected, strobed and not busy
  always @(posedge clk) begin
    if (rst_n) begin
      for (int t = 0; t < NT; t++)
        if (!cs_n[t] && !wr_n && !busy && cap_n[t] < 16) begin
          cap[t][cap_n[t]] = bus_d;
          cap_n[t]++;
        end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if ($countones(~cs_n) > 1) multi_cs++;
      if ((~&cs_n) != !wr_n) split_strobe++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_caps();
    for (int t = 0; t < NT; t++) cap_n[t] = 0;
  endtask

  task automatic do_reset(input logic [15:0] lim);
    rst_n = 0; s_valid = 0; s_last = 0; busy = 0; cfg_done = 0; to_limit = lim;
    repeat (3) @(negedge clk);
    clear_caps();
    rst_n = 1;
    @(negedge clk); #1;
  endtask

  task automatic load_img(input logic [1:0] t, input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      s_valid = 1; s_data = base + 8'(i); s_tgt = t; s_last = (i == n-1);
      #1;
      while (!s_ready) begin @(negedge clk); #1; end
      @(negedge clk);
    end
    s_valid = 0; s_last = 0;
    @(negedge clk); #1;
  endtask

  task automatic t_reset();
    chk("R1 cs_n", cs_n, 4'hF);
    chk("R1 wr_n", wr_n, 1);
    chk("R1 oe", bus_oe, 0);
    chk("R1 ready", s_ready, 1);
    chk("R1 flags", {loading, startup_go, done_timeout}, 0);
    chk("R1 count", byte_cnt, 0);
  endtask

  task automatic t_plain();
    load_img(2'd2, 3, 8'h20);
    chk("R4 bytes at target2", cap_n[2], 3);
    chk("R4 byte0", cap[2][0], 8'h20);
    chk("R4 byte2", cap[2][2], 8'h22);
    chk("R8 count after close", byte_cnt, 3);
    chk("R6 released", {cs_n, wr_n}, 5'h1F);
    chk("R11 other targets silent", cap_n[0] + cap_n[1] + cap_n[3], 0);
  endtask

  task automatic t_busy();
    s_valid = 1; s_data = 8'hA0; s_tgt = 2'd0; s_last = 0;
    @(negedge clk);
    busy = 1; s_data = 8'hA1; s_last = 1; #1;
    chk("R2 select", cs_n, 4'b1110);
    chk("R2 strobe", wr_n, 0);
    chk("R7 oe on", bus_oe, 1);
    chk("R2 data", bus_d, 8'hA0);
    chk("R2 active", active_tgt, 0);
    chk("R8 cleared at open", byte_cnt, 0);
    chk("R3 ready low", s_ready, 0);
    repeat (3) begin
      @(negedge clk); #1;
      chk("R3 held data", bus_d, 8'hA0);
      chk("R3 held select", {cs_n, wr_n}, 5'b11100);
    end
    chk("R3 nothing taken", cap_n[0], 0);
    busy = 0; #1;
    chk("R4 ready after busy", s_ready, 1);
    @(negedge clk); #1;
    chk("R4 next byte", bus_d, 8'hA1);
    chk("R8 count 1", byte_cnt, 1);
    chk("R6 ready low on last", s_ready, 0);
    s_valid = 0; s_last = 0;
    @(negedge clk); #1;
    chk("R6 released", {cs_n, wr_n}, 5'h1F);
    chk("R7 oe off", bus_oe, 0);
    chk("R8 count 2", byte_cnt, 2);
    chk("R4 target0 count", cap_n[0], 2);
    chk("R4 target0 order", {cap[0][0], cap[0][1]}, 16'hA0A1);
  endtask

  task automatic t_gap();
    cfg_done = 1;
    s_valid = 1; s_data = 8'hB0; s_tgt = 2'd1; s_last = 0;
    @(negedge clk);
    s_valid = 0;
    @(negedge clk); #1;
    chk("R5 gap releases", {cs_n, wr_n}, 5'h1F);
    chk("R5 transfer open", loading, 1);
    chk("R9 done ignored early", startup_go, 0);
    cfg_done = 0;
    s_valid = 1; s_data = 8'hB1; s_tgt = 2'd3; s_last = 1;
    @(negedge clk); #1;
    chk("R2 later index ignored", cs_n, 4'b1101);
    chk("R2 active kept", active_tgt, 1);
    s_valid = 0; s_last = 0;
    @(negedge clk); #1;
    chk("R5 target1 bytes", cap_n[1], 2);
    chk("R2 target3 untouched", cap_n[3], 0);
    chk("R9 not waiting", s_ready, 1);
  endtask

  task automatic t_timeout();
    load_img(2'd3, 2, 8'hC0);
    chk("R9 ready low once all loaded", s_ready, 0);
    chk("R4 target3 bytes", cap_n[3], 2);
    repeat (4) @(negedge clk);
    #1 chk("R10 not yet", done_timeout, 0);
    @(negedge clk); #1;
    chk("R10 rises at limit", done_timeout, 1);
    chk("R9 no startup yet", startup_go, 0);
    cfg_done = 1;
    @(negedge clk); #1;
    chk("R9 startup", startup_go, 1);
    chk("R10 sticky", done_timeout, 1);
  endtask

  task automatic t_no_timeout();
    do_reset(16'd0);
    for (int t = 0; t < NT; t++) load_img(2'(t), 1, 8'(8'h50 + t));
    repeat (40) @(negedge clk);
    #1 chk("R10 zero limit disables", done_timeout, 0);
    chk("R9 waiting ready low", s_ready, 0);
    cfg_done = 1;
    @(negedge clk); #1;
    chk("R9 startup after done", startup_go, 1);
    chk("R11 single select", multi_cs, 0);
    chk("R5 strobe matches select", split_strobe, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    do_reset(16'd5);
    t_reset();
    t_plain();
    t_busy();
    t_gap();
    t_timeout();
    t_no_timeout();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule